// File: doc/BRIEF.md
# Dual-Lane Cascaded 8b/10b Encoder

This block turns a 16-bit word into two 10-bit 8b/10b code groups on every clock, one group per byte lane. Each lane has its own control flag that selects a control character in place of a data character. The running disparity is passed from one lane to the next inside the same clock cycle. The upper byte is the one sent first on the serial line, so it starts from the disparity left by the previous word. The lower byte starts from the disparity that the upper byte ends with.

The data path has registers at its input and output, which gives a fixed latency. A word sampled on edge n is on the outputs after edge n+2. The disparity override pair (a force flag and a disparity value) does not pass through these registers. This lets an external encoder, or a test harness, set the starting disparity at the moment the word is encoded, which is `IN_STAGES` cycles after the word was applied. When no data is enabled, an idle request makes both lanes send a K28.5 character. The lane count and the input pipeline depth are parameters.

Top module: `enc8b10b_dual`

## Requirements
- R1: While `rst_n` is low and after it is released, `valid` is 0, `kerr` is 0, `dataout` is 0, and `rd_out` is 0. Running disparity is 0 for negative and 1 for positive, and it starts negative.
- R2: `ena`, `idle_ins`, `kin` and `datain` sampled on rising edge n set `valid` and `dataout` after edge n+2, so they can be sampled on edge n+3 (default `IN_STAGES`=2; the latency is `IN_STAGES`+1 edges).
- R3: A data byte HGFEDCBA (bit 7 = H) is encoded with the 5b/6b sub-block taken from EDCBA and the 3b/4b sub-block taken from HGF. The lane's group is `{a,b,c,d,e,i,f,g,h,j}`, with `a` in the group's most significant bit, so bit 9 is sent first. The upper byte goes to `dataout[19:10]` and the lower byte to `dataout[9:0]`. Each group holds four, five or six ones.
- R4: The upper lane starts from the carried disparity. The lower lane starts from the upper lane's ending disparity. `rd_out` gives the lower lane's ending disparity, aligned with `dataout`. The serial running digital sum stays within ±1 at every group boundary.
- R5: The 3b/4b code for x.7 uses the alternate form whenever the primary form would give a run of five equal bits at the e/i–f/g boundary. This covers D.17/18/20.7 at negative disparity and D.11/13/14.7 at positive disparity. No run in the serial stream is longer than five bits.
- R6: With the lane's `kin` bit high, the 12 control bytes K28.0–K28.7, K23.7, K27.7, K29.7 and K30.7 are encoded as control characters, and that lane's `kerr` stays 0.
- R7: If a lane's `kin` bit is high and its byte is not one of the 12 control bytes, that lane's `kerr` is 1 in the same cycle as the word's `valid`. The group is the data encoding of the byte. `kerr` is never 1 while `valid` is 0.
- R8: With `ena` low and `idle_ins` high, every lane sends K28.5 (byte 0xBC) with the correct disparity. `valid` is 1, `kerr` is 0, and `datain` and `kin` are ignored.
- R9: When `ena` and `idle_ins` are both high, the data word is encoded and no idle character is inserted.
- R10: When `ena` and `idle_ins` are both low, `valid` and `kerr` go low, while `dataout` and `rd_out` keep their previous values.
- R11: If `rd_force` is high in the cycle a word is being encoded (the `IN_STAGES` cycles after its data), the upper lane starts from `rd_in` and not from the carried disparity. In a cycle with no word to encode, `rd_force` and `rd_in` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ena | input | 1 | Encode the word on `datain` |
| idle_ins | input | 1 | Insert K28.5 when `ena` is low |
| datain | input | 8*LANES | Byte per lane, upper byte sent first |
| kin | input | LANES | Control-character flag per lane |
| rd_force | input | 1 | Use `rd_in` as the starting disparity (not pipelined) |
| rd_in | input | 1 | External starting disparity, 1 = positive |
| dataout | output | 10*LANES | Code groups, upper lane in the top bits |
| valid | output | 1 | `dataout` carries a new word |
| kerr | output | LANES | Invalid control byte per lane |
| rd_out | output | 1 | Ending running disparity of the word |

## Verification
The bench uses the default values: two lanes and two input stages. Two lanes bring the same-cycle disparity hand-off between lanes within reach, and two input stages give the three-edge latency. They also place the unpipelined override two cycles after its data, so a skew between the force path and the data path shows up as wrong code groups. The random stimulus mixes valid and invalid control bytes, idle and gap cycles, and overrides that land on both encoded and empty cycles. Independent run-length and running-sum tracking of the serial order exposes errors in the alternate-code selection.

// File: rtl/enc8b10b_pkg.sv
package enc8b10b_pkg;

   // K28.5 byte: y = 5, x = 28
   localparam logic [7:0] IDLE_CHR = 8'hBC;

   // 5b/6b sub-block at negative running disparity, bits abcdei
   function automatic logic [5:0] sb6_neg(input logic [4:0] x);
      logic [5:0] r;
      case (x)
         5'd0:  r = 6'b100111;  5'd1:  r = 6'b011101;
         5'd2:  r = 6'b101101;  5'd3:  r = 6'b110001;
         5'd4:  r = 6'b110101;  5'd5:  r = 6'b101001;
         5'd6:  r = 6'b011001;  5'd7:  r = 6'b111000;
         5'd8:  r = 6'b111001;  5'd9:  r = 6'b100101;
         5'd10: r = 6'b010101;  5'd11: r = 6'b110100;
         5'd12: r = 6'b001101;  5'd13: r = 6'b101100;
         5'd14: r = 6'b011100;  5'd15: r = 6'b010111;
         5'd16: r = 6'b011011;  5'd17: r = 6'b100011;
         5'd18: r = 6'b010011;  5'd19: r = 6'b110010;
         5'd20: r = 6'b001011;  5'd21: r = 6'b101010;
         5'd22: r = 6'b011010;  5'd23: r = 6'b111010;
         5'd24: r = 6'b110011;  5'd25: r = 6'b100110;
         5'd26: r = 6'b010110;  5'd27: r = 6'b110110;
         5'd28: r = 6'b001110;  5'd29: r = 6'b101110;
         5'd30: r = 6'b011110;  default: r = 6'b101011;
      endcase
      return r;
   endfunction

   // 3b/4b sub-block at negative running disparity, bits fghj (y = 7: primary form)
   function automatic logic [3:0] sb4_neg(input logic [2:0] y);
      logic [3:0] r;
      case (y)
         3'd0: r = 4'b1011;  3'd1: r = 4'b1001;
         3'd2: r = 4'b0101;  3'd3: r = 4'b1100;
         3'd4: r = 4'b1101;  3'd5: r = 4'b1010;
         3'd6: r = 4'b0110;  default: r = 4'b1110;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/enc8b10b_pipe.sv
module enc8b10b_pipe #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES == 0) begin : g_wire
         assign q_o = d_i;
      end else begin : g_regs
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) stg[s] <= '0;
            end else begin
               stg[0] <= d_i;
               for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
            end
         end
         assign q_o = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/enc8b10b_lane.sv
module enc8b10b_lane
   import enc8b10b_pkg::*;
(
   input  logic [7:0] chr_i,
   input  logic       k_i,
   input  logic       rd_i,
   output logic [9:0] code_o,
   output logic       rd_o,
   output logic       kerr_o
);
   logic [4:0] x;
   logic [2:0] y;
   logic       k28, kok, bal6, bal4, rd6, alt7;
   logic [5:0] six;
   logic [3:0] four;

   always_comb begin
      x    = chr_i[4:0];
      y    = chr_i[7:5];
      k28  = k_i && (x == 5'd28);
      kok  = k28 || (k_i && (y == 3'd7) &&
             ((x == 5'd23) || (x == 5'd27) || (x == 5'd29) || (x == 5'd30)));

      // 5b/6b stage: unbalanced groups and D.7 flip at positive disparity
      six  = k28 ? 6'b001111 : sb6_neg(x);
      bal6 = ($countones(six) == 3);
      if (rd_i && (!bal6 || (x == 5'd7 && !k28))) six = ~six;
      rd6  = bal6 ? rd_i : ~rd_i;

      // 3b/4b stage: alternate x.7 where the primary form would run to five
      alt7 = kok
          || (!rd6 && ((x == 5'd17) || (x == 5'd18) || (x == 5'd20)))
          || ( rd6 && ((x == 5'd11) || (x == 5'd13) || (x == 5'd14)));
      if (y == 3'd7) four = alt7 ? 4'b0111 : 4'b1110;
      else           four = sb4_neg(y);
      bal4 = ($countones(four) == 2);
      if (rd6 && (!bal4 || (y == 3'd3))) four = ~four;
      if (k28 && !rd6 && ((y == 3'd1) || (y == 3'd2) || (y == 3'd5) || (y == 3'd6)))
         four = ~four;

      rd_o   = bal4 ? rd6 : ~rd6;
      code_o = {six, four};
      kerr_o = k_i && !kok;
   end
endmodule

// File: rtl/enc8b10b_dual.sv
module enc8b10b_dual
   import enc8b10b_pkg::*;
#(
   parameter int LANES     = 2,
   parameter int IN_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ena,
   input  logic                 idle_ins,
   input  logic [8*LANES-1:0]   datain,
   input  logic [LANES-1:0]     kin,
   input  logic                 rd_force,
   input  logic                 rd_in,
   output logic [10*LANES-1:0]  dataout,
   output logic                 valid,
   output logic [LANES-1:0]     kerr,
   output logic                 rd_out
);
   localparam int DW = 8 * LANES;
   localparam int CW = 10 * LANES;
   localparam int PW = DW + LANES + 2;

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("enc8b10b_dual: LANES must be at least 1");
      end
      if (IN_STAGES < 0 || IN_STAGES > 4) begin : g_bad_stages
         $error("enc8b10b_dual: IN_STAGES must lie in 0..4");
      end
   endgenerate

   // input pipeline: data, flags and enables travel together
   logic [PW-1:0]    pin, pout;
   logic             s_ena, s_idle, s_fire;
   logic [LANES-1:0] s_k;
   logic [DW-1:0]    s_data;

   assign pin = {ena, idle_ins, kin, datain};

   enc8b10b_pipe #(.W(PW), .STAGES(IN_STAGES)) u_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin),
      .q_o   (pout)
   );

   assign {s_ena, s_idle, s_k, s_data} = pout;
   assign s_fire = s_ena | s_idle;

   // disparity chain: highest lane first, override bypasses the pipeline
   logic [LANES:0]   rdc;
   logic [CW-1:0]    codes;
   logic [LANES-1:0] kerrs;
   logic             rd_q;

   assign rdc[LANES] = rd_force ? rd_in : rd_q;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [7:0] chr;
      logic       kk;
      assign chr = s_ena ? s_data[8*i +: 8] : IDLE_CHR;
      assign kk  = s_ena ? s_k[i] : 1'b1;

      enc8b10b_lane u_lane (
         .chr_i  (chr),
         .k_i    (kk),
         .rd_i   (rdc[i+1]),
         .code_o (codes[10*i +: 10]),
         .rd_o   (rdc[i]),
         .kerr_o (kerrs[i])
      );
   end

   // output register
   logic [CW-1:0]    dout_q;
   logic             valid_q;
   logic [LANES-1:0] kerr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q  <= '0;
         valid_q <= 1'b0;
         kerr_q  <= '0;
         rd_q    <= 1'b0;
      end else begin
         valid_q <= s_fire;
         if (s_fire) begin
            dout_q <= codes;
            kerr_q <= kerrs;
            rd_q   <= rdc[0];
         end else begin
            kerr_q <= '0;
         end
      end
   end

   assign dataout = dout_q;
   assign valid   = valid_q;
   assign kerr    = kerr_q;
   assign rd_out  = rd_q;
endmodule

// File: rtl/enc8b10b_dual_chk.sv
module enc8b10b_dual_chk #(
   parameter int LANES = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                valid,
   input logic [LANES-1:0]    kerr,
   input logic [10*LANES-1:0] dataout,
   input logic                rd_out,
   input logic                rd_force
);
   // ending disparity implied by a starting disparity and the emitted groups
   function automatic logic rd_after(input logic start, input logic [10*LANES-1:0] d);
      int acc;
      acc = start ? 1 : -1;
      for (int l = 0; l < LANES; l++)
         acc = acc + 2 * $countones(d[10*l +: 10]) - 10;
      return (acc > 0);
   endfunction

   function automatic logic groups_ok(input logic [10*LANES-1:0] d);
      logic ok;
      ok = 1'b1;
      for (int l = 0; l < LANES; l++)
         if ($countones(d[10*l +: 10]) < 4 || $countones(d[10*l +: 10]) > 6) ok = 1'b0;
      return ok;
   endfunction

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> ($stable(dataout) && $stable(rd_out)));

   p_kerr_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (kerr != '0) |-> valid);

   p_group_balance_r3: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> groups_ok(dataout));

   p_rd_chain_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !$past(rd_force)) |-> (rd_out == rd_after($past(rd_out), dataout)));
endmodule

bind enc8b10b_dual enc8b10b_dual_chk #(.LANES(LANES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .valid    (valid),
   .kerr     (kerr),
   .dataout  (dataout),
   .rd_out   (rd_out),
   .rd_force (rd_force)
);

// File: tb/enc8b10b_dual_bench.sv
`timescale 1ns/1ps
module enc8b10b_dual_bench;
   localparam int LANES = 2;
   localparam int N     = 3000;
   localparam int AS    = N + 8;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        ena, idle_ins, rd_force, rd_in;
   logic [15:0] datain;
   logic [1:0]  kin;
   logic [19:0] dataout;
   logic        valid, rd_out;
   logic [1:0]  kerr;

   always #2.5 clk = ~clk;

   enc8b10b_dual u_enc8b10b_dual (
      .clk(clk), .rst_n(rst_n), .ena(ena), .idle_ins(idle_ins),
      .datain(datain), .kin(kin), .rd_force(rd_force), .rd_in(rd_in),
      .dataout(dataout), .valid(valid), .kerr(kerr), .rd_out(rd_out)
   );

   int checks = 0;
   int failures = 0;
   bit done = 0;

   logic        a_ena [AS];
   logic        a_idl [AS];
   logic [15:0] a_dat [AS];
   logic [1:0]  a_k   [AS];
   logic        a_frc [AS];
   logic        a_rdi [AS];

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [5:0] t6(input logic [4:0] x);
      logic [5:0] r;
      case (x)
         0: r = 6'b100111;  1: r = 6'b011101;  2: r = 6'b101101;  3: r = 6'b110001;
         4: r = 6'b110101;  5: r = 6'b101001;  6: r = 6'b011001;  7: r = 6'b111000;
         8: r = 6'b111001;  9: r = 6'b100101; 10: r = 6'b010101; 11: r = 6'b110100;
        12: r = 6'b001101; 13: r = 6'b101100; 14: r = 6'b011100; 15: r = 6'b010111;
        16: r = 6'b011011; 17: r = 6'b100011; 18: r = 6'b010011; 19: r = 6'b110010;
        20: r = 6'b001011; 21: r = 6'b101010; 22: r = 6'b011010; 23: r = 6'b111010;
        24: r = 6'b110011; 25: r = 6'b100110; 26: r = 6'b010110; 27: r = 6'b110110;
        28: r = 6'b001110; 29: r = 6'b101110; 30: r = 6'b011110; default: r = 6'b101011;
      endcase
      return r;
   endfunction

   function automatic logic [3:0] t4(input logic [2:0] y);
      logic [3:0] r;
      case (y)
         0: r = 4'b1011; 1: r = 4'b1001; 2: r = 4'b0101; 3: r = 4'b1100;
         4: r = 4'b1101; 5: r = 4'b1010; default: r = 4'b0110;
      endcase
      return r;
   endfunction

   // K28.y fghj at negative starting disparity
   function automatic logic [3:0] k28t(input logic [2:0] y);
      logic [3:0] r;
      case (y)
         0: r = 4'b0100; 1: r = 4'b1001; 2: r = 4'b0101; 3: r = 4'b0011;
         4: r = 4'b0010; 5: r = 4'b1010; 6: r = 4'b0110; default: r = 4'b1000;
      endcase
      return r;
   endfunction

   function automatic bit valid_k(input logic [7:0] b);
      return (b[4:0] == 5'd28) ||
             (b[7:5] == 3'd7 && (b[4:0] == 23 || b[4:0] == 27 || b[4:0] == 29 || b[4:0] == 30));
   endfunction

   function automatic logic [7:0] kbyte(input int i);
      logic [4:0] xs [4];
      xs = '{5'd23, 5'd27, 5'd29, 5'd30};
      if (i < 8) return {i[2:0], 5'd28};
      return {3'd7, xs[i-8]};
   endfunction

   // reference encoder: run-avoidance decides the alternate x.7 form
   task automatic ref_enc(input logic [7:0] b, input logic k, input logic rd,
                          output logic [9:0] g, output logic rdn);
      logic [4:0] x;
      logic [2:0] y;
      logic [5:0] s6;
      logic [3:0] f4, p7;
      logic       r6;
      x = b[4:0];
      y = b[7:5];
      if (k && x == 5'd28) begin
         g = {6'b001111, k28t(y)};
         if (rd) g = ~g;
      end else begin
         s6 = t6(x);
         if (rd && ($countones(s6) != 3 || x == 5'd7)) s6 = ~s6;
         r6 = ($countones(s6) == 3) ? rd : ~rd;
         if (y == 3'd7) begin
            p7 = r6 ? 4'b0001 : 4'b1110;
            if ((k && valid_k(b)) || (s6[1:0] == {2{p7[3]}}))
               f4 = r6 ? 4'b1000 : 4'b0111;
            else
               f4 = p7;
         end else begin
            f4 = t4(y);
            if (r6 && ($countones(f4) != 2 || y == 3'd3)) f4 = ~f4;
         end
         g = {s6, f4};
      end
      rdn = ($countones(g) == 5) ? rd : ~rd;
   endtask

   logic        brd = 1'b0;
   logic [19:0] last_out = '0;
   int          rds = -1;
   int          run_len = 0;
   logic        run_bit = 1'b0;

   task automatic check_word(input int c);
      logic [7:0]  bh, bl;
      logic        kh, kl, st, mid, fin, frc;
      logic [9:0]  gh, gl;
      logic [19:0] ew;
      logic [1:0]  ek;
      string       tag;
      bit          run_ok, rds_ok;
      if (!(a_ena[c] || a_idl[c])) begin
         chk(valid == 1'b0, "R10 valid", valid, 0);
         chk(kerr == 2'b00, "R10 kerr", kerr, 0);
         chk(dataout == last_out, "R10 dataout hold", dataout, last_out);
         chk(rd_out == brd, "R10/R11 rd_out hold", rd_out, brd);
         return;
      end
      frc = a_frc[c+2];
      st  = frc ? a_rdi[c+2] : brd;
      if (a_ena[c]) begin
         bh = a_dat[c][15:8]; kh = a_k[c][1];
         bl = a_dat[c][7:0];  kl = a_k[c][0];
      end else begin
         bh = 8'hBC; kh = 1'b1; bl = 8'hBC; kl = 1'b1;
      end
      ref_enc(bh, kh, st, gh, mid);
      ref_enc(bl, kl, mid, gl, fin);
      ew = {gh, gl};
      ek = {kh && !valid_k(bh), kl && !valid_k(bl)};
      if (frc)                          tag = "R11";
      else if (a_ena[c] && a_idl[c])    tag = "R9";
      else if (!a_ena[c])               tag = "R8";
      else if (kh || kl)                tag = "R6";
      else                              tag = "R3";
      chk(valid == 1'b1, "R2 valid latency", valid, 1);
      chk(dataout[19:10] == gh, {tag, " upper group"}, dataout[19:10], gh);
      chk(dataout[9:0] == gl, "R4 lower group chained", dataout[9:0], gl);
      chk(rd_out == fin, "R4 rd_out", rd_out, fin);
      chk(kerr == ek, "R7 kerr", kerr, ek);
      // serial-order run length and running sum
      if (frc) begin
         rds = st ? 1 : -1;
         run_len = 0;
      end
      run_ok = 1'b1;
      rds_ok = 1'b1;
      for (int b = 19; b >= 0; b--) begin
         if (run_len > 0 && dataout[b] == run_bit) run_len++;
         else begin run_bit = dataout[b]; run_len = 1; end
         if (run_len > 5) run_ok = 1'b0;
         rds += dataout[b] ? 1 : -1;
         if (b == 10 || b == 0)
            if (rds > 1 || rds < -1) rds_ok = 1'b0;
      end
      chk(run_ok, "R5 run length", run_len, 5);
      chk(rds_ok, "R4 running sum", rds, 1);
      brd = fin;
      last_out = dataout;
   endtask

   task automatic drive(input int j);
      logic [7:0] b [2];
      logic [1:0] kk;
      logic       e, id, f, ri;
      int         r;
      e = 1'b1; id = 1'b0; f = 1'b0; ri = 1'b0; kk = 2'b00;
      b[0] = 8'h00; b[1] = 8'h00;
      if (j >= N) begin
         e = 1'b0;
      end else if (j < 12) begin                 // R6 all control bytes
         b[1] = kbyte(j); b[0] = kbyte(11 - j); kk = 2'b11;
      end else if (j < 18) begin                 // R8 idle with junk data
         e = 1'b0; id = 1'b1; b[1] = 8'h55; b[0] = 8'h01; kk = 2'b11;
      end else if (j < 22) begin                 // R10 gaps
         e = 1'b0;
      end else if (j < 26) begin                 // R9 ena wins over idle
         id = 1'b1; b[1] = 8'h2A + j[7:0]; b[0] = 8'h91;
      end else if (j < 30) begin                 // R7 invalid control bytes
         b[1] = 8'h1D; b[0] = 8'hFF; kk = 2'b11;
      end else if (j < 54) begin                 // R5 x.7 corners, both disparities
         r = j - 30;
         case (r % 6)
            0: b[1] = 8'hF1; 1: b[1] = 8'hF2; 2: b[1] = 8'hF4;
            3: b[1] = 8'hEB; 4: b[1] = 8'hED; default: b[1] = 8'hEE;
         endcase
         b[0] = (r < 12) ? 8'h00 : 8'hE7;
      end else begin
         r = int'($urandom_range(15, 0));
         e  = (r != 0 && r != 1);
         id = (r <= 2) || (r == 9);
         for (int l = 0; l < 2; l++) begin
            kk[l] = ($urandom_range(3, 0) == 0);
            if (kk[l] && $urandom_range(1, 0) == 1) b[l] = kbyte(int'($urandom_range(11, 0)));
            else b[l] = 8'($urandom_range(255, 0));
         end
         if (j >= N / 2) begin                   // R11 override, sometimes on empty cycles
            f  = ($urandom_range(7, 0) == 0);
            ri = 1'($urandom_range(1, 0));
         end
      end
      ena = e; idle_ins = id; datain = {b[1], b[0]}; kin = kk;
      rd_force = f; rd_in = ri;
      a_ena[j] = e; a_idl[j] = id; a_dat[j] = {b[1], b[0]}; a_k[j] = kk;
      a_frc[j] = f; a_rdi[j] = ri;
   endtask

   initial begin
      void'($urandom(32'h5EED));
      rst_n = 1'b0;
      ena = 1'b0; idle_ins = 1'b0; datain = '0; kin = '0; rd_force = 1'b0; rd_in = 1'b0;
      repeat (3) @(negedge clk);
      chk(valid == 1'b0, "R1 valid", valid, 0);
      chk(kerr == 2'b00, "R1 kerr", kerr, 0);
      chk(dataout == 20'd0, "R1 dataout", dataout, 0);
      chk(rd_out == 1'b0, "R1 rd_out", rd_out, 0);
      for (int j = 0; j < N + 4; j++) begin
         if (j >= 3) check_word(j - 3);
         if (j == 0) rst_n = 1'b1;
         drive(j);
         @(negedge clk);
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 200000, N);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule